// File: doc/BRIEF.md
# System Control Register Bank

A bank of 32-bit control words behind a zero-wait-state APB-style slave port. The bank decodes a 4 KiB byte window into 512 stored words; software can read and write any word. The board-level control firmware uses one word in the upper part of the window as a power command register: writing a code there asks the system for a reset or a shutdown through a one-cycle request pulse, while the written value is also kept like any other word.

Three identification words near the start of the window come out of reset with fixed values and, on every read, show two status bits forced high without those bits ever being stored. A fourth word between them holds a revision code. All other words come out of reset at zero. What the system does with the request pulses is outside this block.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, reads return 0x05F20121 | 0x30000000 at byte offset 0x100, 0x00000002 at 0x104, 0x05F30121 | 0x30000000 at 0x108 and 0x05F40121 | 0x30000000 at 0x10C.
- R2: After reset every other word reads zero, and prdata_o, rst_req_o and shd_req_o are low while rst_ni is low.
- R3: A write (psel_i, penable_i and pwrite_i high at a clock edge) stores pwdata_i in word paddr_i[10:2]; paddr_i[1:0] are ignored and offsets differing only in paddr_i[11] share one word.
- R4: A read at exactly byte offset 0x100, 0x108 or 0x10C returns the stored word OR 0x30000000 without changing it; reads at 0x104 or at the aliases 0x900, 0x908, 0x90C carry no forced bits.
- R5: A write of 1 or 2 to byte offset 0xF00 (paddr_i[11:2] = 0x3C0) drives rst_req_o high in the cycle following the write edge.
- R6: A write of 3 to byte offset 0xF00 drives shd_req_o high in the cycle following the write edge.
- R7: Any other value written to 0xF00, and any write elsewhere (the storage alias 0x700 included), raises neither request; the two requests are never high together.
- R8: A write to 0xF00 is also stored and reads back unchanged at 0xF00 and 0x700.
- R9: Each request stays high for exactly one cycle.
- R10: Read data is captured at the setup-phase edge (psel_i high, penable_i low, pwrite_i low) and is valid on prdata_o throughout the following access phase; no wait states are inserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase marker |
| pwrite_i | input | 1 | High for a write transfer |
| paddr_i | input | 12 | Byte offset within the window |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Registered read data |
| rst_req_o | output | 1 | One-cycle system reset request |
| shd_req_o | output | 1 | One-cycle system shutdown request |

## Verification
On every cycle the assertions check that the two requests are exclusive, one cycle wide and caused only by the matching command code, that a write lands in its word, that the identification reads carry the forced bits and that read data holds outside the setup phase. Only the bench's scenarios show the reset contents, the aliasing of the upper half of the window, the absence of forced bits at neighbouring and aliased offsets, and that a command write reads back.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned DATA_W      = 32;
  localparam int unsigned ADDR_W      = 12;
  localparam int unsigned WIDX_W      = ADDR_W - 2;
  localparam int unsigned STORE_WORDS = 512;
  localparam int unsigned SIDX_W      = $clog2(STORE_WORDS);
  localparam int unsigned N_OVL       = 3;

  localparam logic [WIDX_W-1:0] CMD_WIDX = 10'h3C0;
  localparam logic [DATA_W-1:0] OVL_BITS = 32'h3000_0000;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_RESET    = 2'd1,
    CMD_SHUTDOWN = 2'd2
  } cmd_e;

  // full word indices that read with forced status bits
  function automatic logic [WIDX_W-1:0] ovl_widx(int unsigned k);
    case (k)
      0:       return 10'h040;
      1:       return 10'h042;
      default: return 10'h043;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] word_reset(int unsigned idx);
    case (idx)
      32'h40:  return 32'h05F2_0121;
      32'h41:  return 32'h0000_0002;
      32'h42:  return 32'h05F3_0121;
      32'h43:  return 32'h05F4_0121;
      default: return '0;
    endcase
  endfunction

  function automatic cmd_e decode_cmd(logic [DATA_W-1:0] d);
    if (d == 32'd1 || d == 32'd2) return CMD_RESET;
    if (d == 32'd3)               return CMD_SHUTDOWN;
    return CMD_NONE;
  endfunction

endpackage

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int unsigned WORDS = STORE_WORDS,
  parameter int unsigned DW    = DATA_W,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o
);

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= DW'(word_reset(i));
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

  assert_store_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mem_q[$past(wr_idx_i)] == $past(wr_data_i)));

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = WIDX_W,
  parameter logic [AW-1:0] CMD_AT = CMD_WIDX
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_widx_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          rst_req_o,
  output logic          shd_req_o
);

  cmd_e cmd;

  always_comb begin
    cmd = CMD_NONE;
    if (wr_en_i && wr_widx_i == CMD_AT) cmd = decode_cmd(32'(wr_data_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o <= 1'b0;
      shd_req_o <= 1'b0;
    end else begin
      rst_req_o <= (cmd == CMD_RESET);
      shd_req_o <= (cmd == CMD_SHUTDOWN);
    end
  end

  assert_req_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_req_o && shd_req_o));

  assert_rst_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_shd_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shd_req_o |=> !shd_req_o);

  assert_rst_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_widx_i == CMD_AT && (wr_data_i == DW'(1) || wr_data_i == DW'(2)))
      |=> rst_req_o);

  assert_shd_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_widx_i == CMD_AT && wr_data_i == DW'(3)) |=> shd_req_o);

  assert_no_stray_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || wr_widx_i != CMD_AT) |=> (!rst_req_o && !shd_req_o));

endmodule

// File: rtl/sysctl_rdpath.sv
module sysctl_rdpath
  import sysctl_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = WIDX_W,
  parameter int unsigned NO = N_OVL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_widx_i,
  input  logic [DW-1:0] stored_i,
  output logic [DW-1:0] rdata_o
);

  logic [NO-1:0] hit;

  for (genvar k = 0; k < NO; k++) begin : g_ovl
    assign hit[k] = (rd_widx_i == AW'(ovl_widx(k)));
  end

  logic [DW-1:0] rdata_d;
  assign rdata_d = (|hit) ? (stored_i | DW'(OVL_BITS)) : stored_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rdata_d;
  end

  assert_ovl_forced_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (|hit)) |=> ((rdata_o & DW'(OVL_BITS)) == DW'(OVL_BITS)));

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned WORDS = STORE_WORDS,
  localparam int unsigned WIW  = AW - 2,
  localparam int unsigned SIW  = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          psel_i,
  input  logic          penable_i,
  input  logic          pwrite_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [DW-1:0] pwdata_i,
  output logic [DW-1:0] prdata_o,
  output logic          rst_req_o,
  output logic          shd_req_o
);

  logic           wr_en, rd_en;
  logic [WIW-1:0] widx;
  logic [SIW-1:0] sidx;
  logic [DW-1:0]  stored;
  logic           unused_lsb;

  assign wr_en      = psel_i & penable_i & pwrite_i;
  assign rd_en      = psel_i & ~penable_i & ~pwrite_i;
  assign widx       = paddr_i[AW-1:2];
  assign sidx       = widx[SIW-1:0];
  assign unused_lsb = ^paddr_i[1:0];

  sysctl_store #(.WORDS(WORDS), .DW(DW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (sidx),
    .wr_data_i (pwdata_i),
    .rd_idx_i  (sidx),
    .rd_data_o (stored)
  );

  sysctl_cmd #(.DW(DW), .AW(WIW), .CMD_AT(WIW'(CMD_WIDX))) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_widx_i (widx),
    .wr_data_i (pwdata_i),
    .rst_req_o (rst_req_o),
    .shd_req_o (shd_req_o)
  );

  sysctl_rdpath #(.DW(DW), .AW(WIW)) u_rdpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en),
    .rd_widx_i (widx),
    .stored_i  (stored),
    .rdata_o   (prdata_o)
  );

endmodule

// File: tb/sysctl_regs_bench.sv
module sysctl_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        rst_req, shd_req;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] model [512];
  bit exp_rst = 0, exp_shd = 0;

  always #5 clk = ~clk;

  sysctl_regs u_sysctl_regs (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .rst_req_o(rst_req), .shd_req_o(shd_req)
  );

  task automatic model_reset();
    for (int i = 0; i < 512; i++) model[i] = 32'h0;
    model[9'h40] = 32'h05F2_0121;
    model[9'h41] = 32'h0000_0002;
    model[9'h42] = 32'h05F3_0121;
    model[9'h43] = 32'h05F4_0121;
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
      exp_rst = 0; exp_shd = 0;
    end else begin
      exp_rst = 0; exp_shd = 0;
      if (psel && penable && pwrite) begin
        model[paddr[10:2]] = pwdata;
        if (paddr[11:2] == 10'h3C0) begin
          exp_rst = (pwdata == 1) || (pwdata == 2);
          exp_shd = (pwdata == 3);
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // request outputs compared every cycle (R5 R6 R7 R9)
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5/R9 rst_req", {31'b0, rst_req}, {31'b0, exp_rst});
      check("R6/R7 shd_req", {31'b0, shd_req}, {31'b0, exp_shd});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  function automatic logic [31:0] expect_rd(logic [11:0] a);
    logic [31:0] v = model[a[10:2]];
    if (a[11:2] == 10'h040 || a[11:2] == 10'h042 || a[11:2] == 10'h043)
      v |= 32'h3000_0000;
    return v;
  endfunction

  task automatic rd(string req, logic [11:0] a);
    logic [31:0] e;
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    e = expect_rd(a);
    #1 check(req, prdata, e);
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic rd_lit(string req, logic [11:0] a, logic [31:0] e);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 check(req, prdata, e);
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset prdata", prdata, 32'h0);
    check("R2 reset rst_req", {31'b0, rst_req}, 32'h0);
    check("R2 reset shd_req", {31'b0, shd_req}, 32'h0);
    rst_n = 1;

    // R1 reset values, literal expectations
    rd_lit("R1 id0", 12'h100, 32'h35F2_0121);
    rd_lit("R1 rev", 12'h104, 32'h0000_0002);
    rd_lit("R1 id1", 12'h108, 32'h35F3_0121);
    rd_lit("R1 id2", 12'h10C, 32'h35F4_0121);
    // R2 other words zero
    rd_lit("R2 word0", 12'h000, 32'h0);
    rd_lit("R2 word7FC", 12'h7FC, 32'h0);
    rd_lit("R2 wordF00", 12'hF00, 32'h0);

    // R3 stores, low address bits ignored, bit 11 aliases
    wr(12'h010, 32'hA5A5_1234);
    rd("R3 plain", 12'h010);
    wr(12'h023, 32'hDEAD_BEEF);
    rd_lit("R3 lsb ignored", 12'h020, 32'hDEAD_BEEF);
    wr(12'h844, 32'h1357_9BDF);
    rd_lit("R3 alias", 12'h044, 32'h1357_9BDF);
    for (int i = 0; i < 8; i++) begin
      wr(12'(12'h200 + i*4), 32'(i * 32'h0101_0101 + 32'h55));
      rd("R3 pattern", 12'(12'h200 + i*4));
    end

    // R4 forced bits not stored
    wr(12'h100, 32'h0);
    rd_lit("R4 id0 zero", 12'h100, 32'h3000_0000);
    rd_lit("R4 alias no force", 12'h900, 32'h0);
    wr(12'h104, 32'h0000_0000);
    rd_lit("R4 rev no force", 12'h104, 32'h0);
    wr(12'h108, 32'h0FFF_FFFF);
    rd_lit("R4 id1", 12'h108, 32'h3FFF_FFFF);
    rd_lit("R4 id1 alias", 12'h908, 32'h0FFF_FFFF);
    rd_lit("R4 id2 alias", 12'h90C, 32'h05F4_0121);

    // R5 R6 R7 R8 commands (pulses checked by the per-cycle monitor)
    wr(12'hF00, 32'd1);
    rd_lit("R8 cmd stored", 12'hF00, 32'd1);
    wr(12'hF00, 32'd2);
    rd_lit("R8 cmd alias", 12'h700, 32'd2);
    wr(12'hF00, 32'd3);
    wr(12'hF00, 32'd0);
    wr(12'hF00, 32'd4);
    wr(12'hF00, 32'hFFFF_FFFF);
    rd_lit("R8 cmd other", 12'hF00, 32'hFFFF_FFFF);
    wr(12'h700, 32'd1);
    wr(12'hF04, 32'd3);
    wr(12'h0F0, 32'd2);
    wr(12'hF01, 32'd3);
    rd_lit("R8 cmd lsb", 12'hF00, 32'd3);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule